// File: doc/BRIEF.md
# Ethernet Destination Address Filter with Multicast Hash

This block decides whether an incoming Ethernet frame is kept or dropped, using its 48-bit destination address, its length and a set of configuration inputs. Group (multicast) destinations are matched against a 64-bit hash table. The table index is six bits taken from a CRC-32 computed over the six address bytes.

The table is written through a load port. A load-start pulse clears the whole table and sets how many entries may follow; the entry count is the byte count divided by six, capped at 64. Each entry is then offered as one 48-bit address per beat. It is hashed one byte per clock, and its table bit is set.

Frames are checked through a request port. The block registers the request, hashes the destination, and some cycles later returns a one-cycle result pulse. The pulse carries an accept flag and a group flag. Only one request is in flight at a time.

Top module: `mcf_filter`

## Requirements
- R1: After reset the table is empty, `load_ready_o` and `chk_valid_o` are low and `chk_ready_o` is high, so a group destination is dropped even with `cfg_mcast_en_i` set.
- R2: The hash is a reflected CRC-32 with polynomial 0xEDB88320 and all-ones start value, with no final inversion. The bytes are processed from `[47:40]` down to `[7:0]`, each least significant bit first. The table index is CRC bits 7:2. Two different group addresses with equal index give the same result.
- R3: A `load_start_i` pulse clears every table bit. The entry count is floor(`load_bytes_i`/6), capped at 64. Once that many addresses have been taken, `load_ready_o` stays low and further addresses are ignored.
- R4: A request is taken when `chk_req_i` and `chk_ready_o` are both high. `chk_ready_o` is low while a check is in flight, and requests in that time are ignored. The result pulse on `chk_valid_o` is one cycle wide and appears on the seventh rising edge after the accepting edge.
- R5: A frame with `chk_len_i` < `cfg_min_len_i` is dropped with the group flag clear, whatever the other settings are.
- R6: In promiscuous mode (`cfg_promisc_i`=1) every frame that is long enough is accepted with the group flag clear.
- R7: An all-ones destination is broadcast. It is dropped when `cfg_bcast_drop_i` is set; otherwise it is accepted with the group flag set.
- R8: Any other destination with bit 40 set (bit 0 of the first byte) is a group address. It is accepted with the group flag set only if `cfg_mcast_en_i` is 1 and its table bit is set; otherwise it is dropped.
- R9: A destination with bit 40 clear is accepted only on an exact 48-bit match with `cfg_station_i`, always with the group flag clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| load_start_i | input | 1 | Clear the table and begin a new list |
| load_bytes_i | input | 16 | Byte count of the new list |
| load_valid_i | input | 1 | Address beat valid |
| load_addr_i | input | 48 | Group address to insert |
| load_ready_o | output | 1 | Load port can take an address |
| chk_req_i | input | 1 | Check request |
| chk_dst_i | input | 48 | Destination address, first byte in bits 47:40 |
| chk_len_i | input | 16 | Frame length in bytes |
| cfg_promisc_i | input | 1 | Accept all frames |
| cfg_bcast_drop_i | input | 1 | Drop broadcast frames |
| cfg_mcast_en_i | input | 1 | Allow hashed group frames |
| cfg_station_i | input | 48 | Own individual address |
| cfg_min_len_i | input | 16 | Minimum frame length |
| chk_ready_o | output | 1 | Check port idle |
| chk_valid_o | output | 1 | Result pulse |
| chk_accept_o | output | 1 | Frame accepted |
| chk_group_o | output | 1 | Accepted as broadcast or group frame |

## Verification
A wrong CRC bit, index slice or byte order moves a group address to another table bit. That shows up as a group frame that is wrongly dropped, or as a frame with a different hash that is wrongly accepted, at the first result pulse after the list is loaded. A clear that misses, or a wrong entry cap, leaves old or surplus entries in the table; the next check of those addresses then accepts when it should drop. A wrong ready or sequencing state shows at the port within eight cycles, as a shifted, stretched or missing result pulse.

// File: rtl/mcf_pkg.sv
package mcf_pkg;
  localparam int unsigned ADDR_W     = 48;
  localparam int unsigned ADDR_BYTES = ADDR_W / 8;
  localparam logic [31:0] CRC_POLY   = 32'hEDB88320;

  function automatic logic [31:0] crc_step(input logic [31:0] c, input logic [7:0] d);
    logic [31:0] r;
    r = c ^ {24'd0, d};
    for (int i = 0; i < 8; i++) r = r[0] ? ((r >> 1) ^ CRC_POLY) : (r >> 1);
    return r;
  endfunction

  typedef struct packed {
    logic short_frame;
    logic promisc;
    logic bcast_drop;
    logic mcast_en;
    logic is_bcast;
    logic is_group;
    logic station_hit;
  } chk_ctx_t;
endpackage

// File: rtl/mcf_crc32.sv
module mcf_crc32
  import mcf_pkg::*;
#(
  parameter int unsigned HASH_LSB = 2,
  parameter int unsigned IDX_W    = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [ADDR_W-1:0] data_i,
  output logic              busy_o,
  output logic              done_o,
  output logic [IDX_W-1:0]  idx_o
);
  localparam int unsigned CNT_W = $clog2(ADDR_BYTES + 1);

  logic [31:0]       crc_q;
  logic [ADDR_W-1:0] sh_q;
  logic [CNT_W-1:0]  cnt_q;
  logic              done_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      crc_q  <= '1;
      sh_q   <= '0;
      cnt_q  <= '0;
      done_q <= 1'b0;
    end else if (start_i) begin
      crc_q  <= '1;
      sh_q   <= data_i;
      cnt_q  <= CNT_W'(ADDR_BYTES);
      done_q <= 1'b0;
    end else if (cnt_q != '0) begin
      crc_q  <= crc_step(crc_q, sh_q[ADDR_W-1 -: 8]);  // first byte first
      sh_q   <= sh_q << 8;
      cnt_q  <= cnt_q - 1'b1;
      done_q <= (cnt_q == CNT_W'(1));
    end else begin
      done_q <= 1'b0;
    end
  end

  assign busy_o = (cnt_q != '0);
  assign done_o = done_q;
  assign idx_o  = crc_q[HASH_LSB +: IDX_W];

  AST_START_WHEN_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |-> !busy_o);  // R2
  AST_DONE_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);  // R4
endmodule

// File: rtl/mcf_hash_table.sv
module mcf_hash_table
  import mcf_pkg::*;
#(
  parameter int unsigned ENTRIES  = 64,
  parameter int unsigned HASH_LSB = 2,
  parameter int unsigned LEN_W    = 16,
  localparam int unsigned IDX_W   = $clog2(ENTRIES)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_start_i,
  input  logic [LEN_W-1:0]  load_bytes_i,
  input  logic              load_valid_i,
  input  logic [ADDR_W-1:0] load_addr_i,
  output logic              load_ready_o,
  input  logic [IDX_W-1:0]  lookup_idx_i,
  output logic              lookup_hit_o
);
  localparam int unsigned REM_W = $clog2(ENTRIES + 1);

  logic [ENTRIES-1:0] table_q;
  logic [REM_W-1:0]   rem_q, rem_load;
  logic [LEN_W-1:0]   quot;
  logic               flight_q, crc_start, crc_busy, crc_done;
  logic [IDX_W-1:0]   crc_idx;

  assign quot     = load_bytes_i / LEN_W'(ADDR_BYTES);
  assign rem_load = (quot > LEN_W'(ENTRIES)) ? REM_W'(ENTRIES) : REM_W'(quot);

  assign load_ready_o = (rem_q != '0) && !crc_busy;
  assign crc_start    = load_valid_i && load_ready_o && !load_start_i;

  mcf_crc32 #(.HASH_LSB(HASH_LSB), .IDX_W(IDX_W)) u_crc (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .start_i(crc_start),
    .data_i (load_addr_i),
    .busy_o (crc_busy),
    .done_o (crc_done),
    .idx_o  (crc_idx)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rem_q    <= '0;
      flight_q <= 1'b0;
    end else if (load_start_i) begin
      rem_q    <= rem_load;
      flight_q <= 1'b0;  // a hash from the old list is dropped
    end else if (crc_start) begin
      rem_q    <= rem_q - 1'b1;
      flight_q <= 1'b1;
    end else if (crc_done) begin
      flight_q <= 1'b0;
    end
  end

  for (genvar g = 0; g < ENTRIES; g++) begin : g_bit
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                         table_q[g] <= 1'b0;
      else if (load_start_i)                               table_q[g] <= 1'b0;
      else if (crc_done && flight_q && crc_idx == IDX_W'(g)) table_q[g] <= 1'b1;
    end
  end

  assign lookup_hit_o = table_q[lookup_idx_i];

  AST_CLEAR_ON_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_start_i |=> (table_q == '0));  // R3
  AST_EMPTY_LIST_STAYS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rem_q == '0 && !load_start_i) |=> (rem_q == '0 && !load_ready_o));  // R3
endmodule

// File: rtl/mcf_classify.sv
module mcf_classify
  import mcf_pkg::*;
#(
  parameter int unsigned HASH_LSB = 2,
  parameter int unsigned IDX_W    = 6,
  parameter int unsigned LEN_W    = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              chk_req_i,
  input  logic [ADDR_W-1:0] chk_dst_i,
  input  logic [LEN_W-1:0]  chk_len_i,
  input  logic              cfg_promisc_i,
  input  logic              cfg_bcast_drop_i,
  input  logic              cfg_mcast_en_i,
  input  logic [ADDR_W-1:0] cfg_station_i,
  input  logic [LEN_W-1:0]  cfg_min_len_i,
  output logic [IDX_W-1:0]  lookup_idx_o,
  input  logic              lookup_hit_i,
  output logic              chk_ready_o,
  output logic              chk_valid_o,
  output logic              chk_accept_o,
  output logic              chk_group_o
);
  chk_ctx_t ctx_q;
  logic     crc_start, crc_busy, crc_done;
  logic     dec_acc, dec_grp;

  assign chk_ready_o = !crc_busy;
  assign crc_start   = chk_req_i && chk_ready_o;

  mcf_crc32 #(.HASH_LSB(HASH_LSB), .IDX_W(IDX_W)) u_crc (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .start_i(crc_start),
    .data_i (chk_dst_i),
    .busy_o (crc_busy),
    .done_o (crc_done),
    .idx_o  (lookup_idx_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctx_q <= '0;
    end else if (crc_start) begin
      ctx_q.short_frame <= (chk_len_i < cfg_min_len_i);
      ctx_q.promisc     <= cfg_promisc_i;
      ctx_q.bcast_drop  <= cfg_bcast_drop_i;
      ctx_q.mcast_en    <= cfg_mcast_en_i;
      ctx_q.is_bcast    <= &chk_dst_i;
      ctx_q.is_group    <= chk_dst_i[ADDR_W-8];
      ctx_q.station_hit <= (chk_dst_i == cfg_station_i);
    end
  end

  // priority: length, promiscuous, broadcast, group, individual
  always_comb begin
    dec_acc = 1'b0;
    dec_grp = 1'b0;
    if (ctx_q.short_frame) begin
      dec_acc = 1'b0;
    end else if (ctx_q.promisc) begin
      dec_acc = 1'b1;
    end else if (ctx_q.is_bcast) begin
      dec_acc = !ctx_q.bcast_drop;
      dec_grp = !ctx_q.bcast_drop;
    end else if (ctx_q.is_group) begin
      dec_acc = ctx_q.mcast_en && lookup_hit_i;
      dec_grp = dec_acc;
    end else begin
      dec_acc = ctx_q.station_hit;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      chk_valid_o  <= 1'b0;
      chk_accept_o <= 1'b0;
      chk_group_o  <= 1'b0;
    end else begin
      chk_valid_o  <= crc_done;
      chk_accept_o <= crc_done && dec_acc;
      chk_group_o  <= crc_done && dec_grp;
    end
  end

  AST_SHORT_DROPPED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (crc_done && ctx_q.short_frame) |=> !chk_accept_o);  // R5
  AST_PROMISC_ALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (crc_done && !ctx_q.short_frame && ctx_q.promisc) |=> (chk_accept_o && !chk_group_o));  // R6
  AST_BCAST_DROP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (crc_done && !ctx_q.short_frame && !ctx_q.promisc && ctx_q.is_bcast && ctx_q.bcast_drop)
      |=> !chk_accept_o);  // R7
  AST_GROUP_NEEDS_EN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (crc_done && ctx_q.is_group && !ctx_q.is_bcast && !ctx_q.promisc && !ctx_q.mcast_en)
      |=> !chk_accept_o);  // R8
  AST_BUSY_NOT_READY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    crc_start |=> !chk_ready_o);  // R4
endmodule

// File: rtl/mcf_filter.sv
module mcf_filter
  import mcf_pkg::*;
#(
  parameter int unsigned MAX_GROUPS = 64,
  parameter int unsigned HASH_LSB   = 2,
  parameter int unsigned LEN_W      = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_start_i,
  input  logic [LEN_W-1:0]  load_bytes_i,
  input  logic              load_valid_i,
  input  logic [47:0]       load_addr_i,
  output logic              load_ready_o,
  input  logic              chk_req_i,
  input  logic [47:0]       chk_dst_i,
  input  logic [LEN_W-1:0]  chk_len_i,
  input  logic              cfg_promisc_i,
  input  logic              cfg_bcast_drop_i,
  input  logic              cfg_mcast_en_i,
  input  logic [47:0]       cfg_station_i,
  input  logic [LEN_W-1:0]  cfg_min_len_i,
  output logic              chk_ready_o,
  output logic              chk_valid_o,
  output logic              chk_accept_o,
  output logic              chk_group_o
);
  localparam int unsigned IDX_W = $clog2(MAX_GROUPS);

  logic [IDX_W-1:0] lookup_idx;
  logic             lookup_hit;

  mcf_hash_table #(.ENTRIES(MAX_GROUPS), .HASH_LSB(HASH_LSB), .LEN_W(LEN_W)) u_table (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .load_start_i (load_start_i),
    .load_bytes_i (load_bytes_i),
    .load_valid_i (load_valid_i),
    .load_addr_i  (load_addr_i),
    .load_ready_o (load_ready_o),
    .lookup_idx_i (lookup_idx),
    .lookup_hit_o (lookup_hit)
  );

  mcf_classify #(.HASH_LSB(HASH_LSB), .IDX_W(IDX_W), .LEN_W(LEN_W)) u_classify (
    .clk_i            (clk_i),
    .rst_ni           (rst_ni),
    .chk_req_i        (chk_req_i),
    .chk_dst_i        (chk_dst_i),
    .chk_len_i        (chk_len_i),
    .cfg_promisc_i    (cfg_promisc_i),
    .cfg_bcast_drop_i (cfg_bcast_drop_i),
    .cfg_mcast_en_i   (cfg_mcast_en_i),
    .cfg_station_i    (cfg_station_i),
    .cfg_min_len_i    (cfg_min_len_i),
    .lookup_idx_o     (lookup_idx),
    .lookup_hit_i     (lookup_hit),
    .chk_ready_o      (chk_ready_o),
    .chk_valid_o      (chk_valid_o),
    .chk_accept_o     (chk_accept_o),
    .chk_group_o      (chk_group_o)
  );

  AST_VALID_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    chk_valid_o |=> !chk_valid_o);  // R4
  AST_FLAGS_ONLY_ON_VALID: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !chk_valid_o |-> (!chk_accept_o && !chk_group_o));  // R4
  AST_GROUP_IMPLIES_ACCEPT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    chk_group_o |-> chk_accept_o);  // R8
endmodule

// File: tb/tb_mcf_filter.sv
`timescale 1ns/1ps
module tb_mcf_filter;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        load_start = 1'b0, load_valid = 1'b0;
  logic [15:0] load_bytes = '0;
  logic [47:0] load_addr = '0;
  logic        load_ready;
  logic        chk_req = 1'b0;
  logic [47:0] chk_dst = '0;
  logic [15:0] chk_len = '0;
  logic        promisc = 1'b0, bdrop = 1'b0, men = 1'b0;
  logic        chk_ready, chk_valid, chk_accept, chk_group;

  localparam logic [47:0] STATION = 48'h02_11_22_33_44_55;
  localparam logic [47:0] M1      = 48'h01_00_5e_00_00_01;
  localparam logic [47:0] BCAST   = 48'hff_ff_ff_ff_ff_ff;
  localparam logic [15:0] MIN_LEN = 16'd64;

  always #2.5 clk = ~clk;

  mcf_filter dut (
    .clk_i(clk), .rst_ni(rst_n),
    .load_start_i(load_start), .load_bytes_i(load_bytes),
    .load_valid_i(load_valid), .load_addr_i(load_addr), .load_ready_o(load_ready),
    .chk_req_i(chk_req), .chk_dst_i(chk_dst), .chk_len_i(chk_len),
    .cfg_promisc_i(promisc), .cfg_bcast_drop_i(bdrop), .cfg_mcast_en_i(men),
    .cfg_station_i(STATION), .cfg_min_len_i(MIN_LEN),
    .chk_ready_o(chk_ready), .chk_valid_o(chk_valid),
    .chk_accept_o(chk_accept), .chk_group_o(chk_group)
  );

  int checks = 0;
  int fails  = 0;

  // {dst, len, promisc, bcast_drop, mcast_en, exp_accept, exp_group}
  localparam int NV = 11;
  localparam logic [68:0] VEC [NV] = '{
    {STATION,            16'd64,   5'b000_10},  // R9 exact match
    {48'h02_11_22_33_44_54, 16'd64, 5'b000_00},  // R9 one bit off
    {STATION,            16'd63,   5'b000_00},  // R5 one byte short
    {STATION,            16'd63,   5'b100_00},  // R5 short beats promiscuous
    {48'h0a_00_00_00_00_01, 16'd100, 5'b100_10}, // R6 foreign address
    {BCAST,              16'd64,   5'b000_11},  // R7 broadcast kept
    {BCAST,              16'd64,   5'b010_00},  // R7 broadcast dropped
    {BCAST,              16'd64,   5'b110_10},  // R6 promiscuous over drop
    {M1,                 16'd64,   5'b001_11},  // R8 hashed hit
    {M1,                 16'd64,   5'b000_00},  // R8 group disabled
    {STATION,            16'd1500, 5'b000_10}   // R9 long frame
  };

  function automatic logic [31:0] ref_crc(input logic [47:0] a);
    logic [31:0] c;
    logic [7:0]  b;
    logic        fb;
    c = 32'hffff_ffff;
    for (int i = 0; i < 6; i++) begin
      b = a[47-8*i -: 8];
      for (int j = 0; j < 8; j++) begin
        fb = c[0] ^ b[j];
        c  = c >> 1;
        if (fb) c = c ^ 32'hEDB88320;
      end
    end
    return c;
  endfunction

  function automatic logic [5:0] ref_idx(input logic [47:0] a);
    logic [31:0] c;
    c = ref_crc(a);
    return c[7:2];
  endfunction

  task automatic expect_bit(input logic act, input logic exp, input string tag, input string what);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0b expected %0b", tag, what, act, exp);
    end
  endtask

  // one request; result expected on the 7th rising edge after the accepting edge
  task automatic do_check(input logic [47:0] d, input logic [15:0] len, input logic p,
                          input logic bd, input logic me, input logic eacc,
                          input logic egrp, input string tag);
    logic early;
    @(negedge clk);
    chk_dst = d; chk_len = len; promisc = p; bdrop = bd; men = me; chk_req = 1'b1;
    @(negedge clk);
    chk_req = 1'b0;
    early = 1'b0;
    for (int k = 1; k <= 7; k++) begin
      if (chk_valid) early = 1'b1;
      @(negedge clk);
    end
    expect_bit(early, 1'b0, tag, "early result");
    expect_bit(chk_valid, 1'b1, tag, "result pulse");
    expect_bit(chk_accept, eacc, tag, "accept");
    expect_bit(chk_group, egrp, tag, "group");
    @(negedge clk);
    expect_bit(chk_valid, 1'b0, tag, "pulse width");
  endtask

  logic [47:0] ladr [70];

  task automatic load_list(input int bytes, input int n, input string tag);
    int ent, w;
    ent = bytes / 6;
    if (ent > 64) ent = 64;
    @(negedge clk);
    load_start = 1'b1; load_bytes = 16'(bytes);
    @(negedge clk);
    load_start = 1'b0;
    for (int i = 0; i < n; i++) begin
      if (i < ent) begin
        w = 0;
        while (!load_ready && w < 50) begin @(negedge clk); w++; end
        load_valid = 1'b1; load_addr = ladr[i];
        @(negedge clk);
        load_valid = 1'b0;
      end else begin
        while (w < 20 && dut.load_ready_o === 1'bx) w++;
        repeat (10) @(negedge clk);
        expect_bit(load_ready, 1'b0, tag, "ready after last entry");
        load_valid = 1'b1; load_addr = ladr[i];
        repeat (10) @(negedge clk);
        load_valid = 1'b0;
      end
    end
    repeat (12) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [47:0] m2, m3;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    expect_bit(load_ready, 1'b0, "R1", "load_ready");
    expect_bit(chk_ready, 1'b1, "R1", "chk_ready");
    expect_bit(chk_valid, 1'b0, "R1", "chk_valid");
    do_check(M1, 16'd64, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, "R1");

    ladr[0] = M1;
    load_list(6, 1, "R3");
    for (int v = 0; v < NV; v++)
      do_check(VEC[v][68:21], VEC[v][20:5], VEC[v][4], VEC[v][3], VEC[v][2],
               VEC[v][1], VEC[v][0], $sformatf("vector %0d", v));

    // R2: pick group addresses with other and with equal index
    m2 = M1;
    for (int i = 1; i < 4000 && ref_idx(m2) == ref_idx(M1); i++) m2 = M1 + 48'(i);
    m3 = M1;
    for (int i = 1; i < 4000 && (m3 == M1 || ref_idx(m3) != ref_idx(M1)); i++) m3 = M1 + 48'(i);
    do_check(m2, 16'd64, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, "R2");
    do_check(m3, 16'd64, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, "R2");

    // R4: requests during a check are ignored
    @(negedge clk);
    chk_dst = STATION; chk_len = 16'd64; promisc = 0; bdrop = 0; men = 0; chk_req = 1'b1;
    @(negedge clk);
    expect_bit(chk_ready, 1'b0, "R4", "ready while busy");
    chk_dst = BCAST; bdrop = 1'b1;
    repeat (2) @(negedge clk);
    chk_req = 1'b0;
    repeat (5) @(negedge clk);
    expect_bit(chk_valid, 1'b1, "R4", "first result kept");
    expect_bit(chk_accept, 1'b1, "R4", "first request decided");
    @(negedge clk);
    expect_bit(chk_valid, 1'b0, "R4", "no second result");
    bdrop = 1'b0;

    // R3: new list clears the old one
    ladr[0] = m2;
    load_list(6, 1, "R3");
    do_check(M1, 16'd64, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, "R3");
    do_check(m2, 16'd64, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, "R3");

    // R3: 11 bytes gives one entry
    ladr[0] = M1; ladr[1] = m2;
    load_list(11, 2, "R3");
    do_check(M1, 16'd64, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, "R3");
    do_check(m2, 16'd64, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, "R3");

    // R3: 420 bytes is capped at 64 entries
    for (int i = 0; i < 64; i++) ladr[i] = M1;
    ladr[64] = m2;
    load_list(420, 65, "R3");
    do_check(m2, 16'd64, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, "R3");
    do_check(M1, 16'd64, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, "R3");

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule